// File: doc/BRIEF.md
# Oscillator-Mixer Readout Channel

This block takes a stream of complex baseband samples, each a 32-bit word holding a signed 16-bit in-phase part (I) in bits 15:0 and a signed 16-bit quadrature part (Q) in bits 31:16. It rotates every accepted sample by the phase of an internal numerically controlled oscillator. A 32-bit phase accumulator drives a sine table that the block computes for itself at elaboration. The output stream carries one of three things: the rotated product, the raw oscillator, or the untouched input. It can run freely or stop after a programmed number of words.

Software programs the step, the start phase, the word count, the output choice and the run mode through a write-only register port. These writes land in a staged copy that has no effect on the datapath. The live settings change only when the commit register is written with 1 and then with 0. That commit also reloads the accumulator and restarts the word count. The datapath has no back-pressure. Every input word with valid set is taken, and its result leaves a fixed four cycles later.

Top module: `mixer_readout`

## Requirements
- R1: After reset the live settings are step 0, start phase 0, count 10, output choice product and free-running mode, and m_tvalid is low until samples arrive; with these settings each input yields a product output without any commit.
- R2: Register writes (cfg_addr 0 = step, 1 = start phase, 2 = count in bits 15:0, 3 = output choice in bits 1:0, 4 = run mode in bit 0) change nothing at the outputs until cfg_addr 5 is written with bit 0 = 1 and then with bit 0 = 0; the second write copies all staged values into the live settings at once.
- R3: A commit restarts the accumulated phase at the start phase; the first sample after it uses that phase, and each accepted sample advances the phase by the step modulo 2^32; idle cycles do not advance it.
- R4: The table index for a sample is the top LUT_AW bits of its phase (8 bits by default); the table holds round(32767·sin(2π·k/2^LUT_AW)), and the cosine is read at index k + 2^LUT_AW/4.
- R5: Output choice 1 emits the oscillator: cosine in bits 15:0 and sine in bits 31:16.
- R6: Output choice 0 emits re = I·cos − Q·sin in bits 15:0 and im = I·sin + Q·cos in bits 31:16, each computed as (x + 2^14) >> 15 with an arithmetic shift.
- R7: A rotated result outside −32768..32767 is clamped to the nearer limit.
- R8: Output choice 2 emits the input word bit-for-bit.
- R9: Output choice 3 behaves exactly as choice 0.
- R10: In run mode 0, exactly `count` words are emitted after a commit and later inputs produce nothing until the next commit; a count of 0 emits nothing.
- R11: In run mode 1, every accepted input produces one output word, including back-to-back inputs.
- R12: The result of an input taken at a clock edge appears on m_tvalid/m_tdata after the fourth edge counted from that one, and m_tvalid is never high without a matching input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| s_tvalid | input | 1 | Input sample valid |
| s_tdata | input | 32 | Input sample, I in 15:0, Q in 31:16 |
| m_tvalid | output | 1 | Output word valid |
| m_tdata | output | 32 | Output word, real part in 15:0, imaginary in 31:16 |

## Verification
The bench builds the block with its default table depth of 256 entries. Each table index is then the top byte of the phase, so whole-step and fractional-step phase sequences, quarter-wave points and the 45° point used for clamping can all be aimed at directly. The bench model computes the table with real sine functions and allows a one- or two-LSB tolerance. Bypass output and the word-count gating are checked exactly.

// File: rtl/mixer_readout_pkg.sv
`timescale 1ns/1ps
package mixer_readout_pkg;

    localparam int SMP_W   = 16;
    localparam int PHASE_W = 32;
    localparam int COUNT_W = 16;
    localparam int MIX_W   = 2 * SMP_W + 1;
    localparam int EXT_W   = MIX_W + 1;
    localparam int AMP     = (1 << (SMP_W - 1)) - 1;

    localparam logic [2:0] ADDR_STEP   = 3'd0;
    localparam logic [2:0] ADDR_PHASE  = 3'd1;
    localparam logic [2:0] ADDR_COUNT  = 3'd2;
    localparam logic [2:0] ADDR_SEL    = 3'd3;
    localparam logic [2:0] ADDR_RUN    = 3'd4;
    localparam logic [2:0] ADDR_COMMIT = 3'd5;

    typedef enum logic [1:0] {
        SEL_PRODUCT = 2'd0,
        SEL_OSC     = 2'd1,
        SEL_BYPASS  = 2'd2,
        SEL_ALT     = 2'd3
    } sel_e;

    typedef enum logic {
        RUN_COUNT = 1'b0,
        RUN_FREE  = 1'b1
    } run_e;

    typedef struct packed {
        logic signed [SMP_W-1:0] q;
        logic signed [SMP_W-1:0] i;
    } iq_t;

    typedef struct packed {
        logic [PHASE_W-1:0] step;
        logic [PHASE_W-1:0] phase;
        logic [COUNT_W-1:0] count;
        sel_e               sel;
        run_e               run;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        step:  '0,
        phase: '0,
        count: COUNT_W'(10),
        sel:   SEL_PRODUCT,
        run:   RUN_FREE
    };

    // pi/2 in Q2.30
    localparam longint HALF_PI_Q30 = 64'd1686629713;

    // sine of (pi/2)*num/den in Q2.30 by odd power series
    function automatic longint quarter_sine_q30(input longint num, input longint den);
        longint x;
        longint term;
        longint acc;
        x    = (HALF_PI_Q30 * num) / den;
        term = x;
        acc  = x;
        for (int n = 1; n <= 5; n++) begin
            term = (term * x) >>> 30;
            term = (term * x) >>> 30;
            term = -term / longint'((2 * n) * (2 * n + 1));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // table entry k of an n-entry full-wave sine, amplitude AMP
    function automatic logic signed [SMP_W-1:0] wave_sin(input int k, input int n);
        int     qtr;
        int     m;
        longint v;
        longint amp;
        logic   neg;
        qtr = n / 4;
        m   = k % n;
        neg = 1'b0;
        if (m < qtr) begin
            v = quarter_sine_q30(longint'(m), longint'(qtr));
        end else if (m < 2 * qtr) begin
            v = quarter_sine_q30(longint'(2 * qtr - m), longint'(qtr));
        end else if (m < 3 * qtr) begin
            v   = quarter_sine_q30(longint'(m - 2 * qtr), longint'(qtr));
            neg = 1'b1;
        end else begin
            v   = quarter_sine_q30(longint'(n - m), longint'(qtr));
            neg = 1'b1;
        end
        amp = (v * longint'(AMP) + (longint'(1) <<< 29)) >>> 30;
        if (amp > longint'(AMP)) amp = longint'(AMP);
        if (neg) amp = -amp;
        return SMP_W'(amp);
    endfunction

    localparam logic signed [EXT_W-1:0] RND_HALF = EXT_W'(1) << (SMP_W - 2);
    localparam logic signed [EXT_W-1:0] POS_LIM  = EXT_W'(AMP);
    localparam logic signed [EXT_W-1:0] NEG_LIM  = ~POS_LIM;

    // round a Q(2*SMP_W-1) sum back to SMP_W bits with clamping
    function automatic logic signed [SMP_W-1:0] round_sat(input logic signed [MIX_W-1:0] v);
        logic signed [EXT_W-1:0] t;
        t = ($signed({v[MIX_W-1], v}) + RND_HALF) >>> (SMP_W - 1);
        if (t > POS_LIM)      return POS_LIM[SMP_W-1:0];
        else if (t < NEG_LIM) return NEG_LIM[SMP_W-1:0];
        else                  return t[SMP_W-1:0];
    endfunction

endpackage

// File: rtl/mixer_cfg_regs.sv
`timescale 1ns/1ps
module mixer_cfg_regs
    import mixer_readout_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [2:0]  addr,
    input  logic [31:0] wdata,
    output logic [PHASE_W-1:0] load_phase,
    output cfg_t        live,
    output logic        commit
);

    cfg_t staged;
    logic armed;

    assign commit     = wr && (addr == ADDR_COMMIT) && !wdata[0] && armed;
    assign load_phase = staged.phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged <= CFG_RESET;
            live   <= CFG_RESET;
            armed  <= 1'b0;
        end else begin
            if (wr) begin
                case (addr)
                    ADDR_STEP:   staged.step  <= wdata[PHASE_W-1:0];
                    ADDR_PHASE:  staged.phase <= wdata[PHASE_W-1:0];
                    ADDR_COUNT:  staged.count <= wdata[COUNT_W-1:0];
                    ADDR_SEL:    staged.sel   <= sel_e'(wdata[1:0]);
                    ADDR_RUN:    staged.run   <= run_e'(wdata[0]);
                    ADDR_COMMIT: armed        <= wdata[0];
                    default: ;
                endcase
            end
            if (commit) live <= staged;
        end
    end

    // R2
    config_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(live));

    // R2
    config_commit_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> live == $past(staged));

endmodule

// File: rtl/mixer_nco.sv
`timescale 1ns/1ps
module mixer_nco
    import mixer_readout_pkg::*;
#(
    parameter int LUT_AW = 8
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               commit,
    input  logic [PHASE_W-1:0] load_phase,
    input  logic [PHASE_W-1:0] step,
    input  logic               in_valid,
    input  iq_t                in_data,
    output logic               v2,
    output iq_t                d2,
    output logic signed [SMP_W-1:0] cos2,
    output logic signed [SMP_W-1:0] sin2
);

    localparam int LUT_N = 1 << LUT_AW;
    localparam logic [LUT_AW-1:0] QTR = LUT_AW'(LUT_N / 4);

    logic signed [SMP_W-1:0] sin_tab [LUT_N];

    for (genvar g = 0; g < LUT_N; g++) begin : g_tab
        localparam logic signed [SMP_W-1:0] ENTRY = wave_sin(g, LUT_N);
        assign sin_tab[g] = ENTRY;
    end

    logic [PHASE_W-1:0] acc;
    logic               v1;
    iq_t                d1;
    logic [LUT_AW-1:0]  idx1;
    logic [LUT_AW-1:0]  cidx;

    assign cidx = idx1 + QTR;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            v1   <= 1'b0;
            d1   <= '0;
            idx1 <= '0;
            v2   <= 1'b0;
            d2   <= '0;
            cos2 <= '0;
            sin2 <= '0;
        end else begin
            v1 <= in_valid;
            if (in_valid) begin
                d1   <= in_data;
                idx1 <= acc[PHASE_W-1 -: LUT_AW];
            end
            if (commit)        acc <= load_phase;
            else if (in_valid) acc <= acc + step;

            v2 <= v1;
            if (v1) begin
                d2   <= d1;
                sin2 <= sin_tab[idx1];
                cos2 <= sin_tab[cidx];
            end
        end
    end

    // R3
    phase_reload_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> acc == $past(load_phase));

    // R3
    phase_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!commit && !in_valid) |=> $stable(acc));

endmodule

// File: rtl/mixer_cmul.sv
`timescale 1ns/1ps
module mixer_cmul
    import mixer_readout_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    v2,
    input  iq_t                     d2,
    input  logic signed [SMP_W-1:0] cos2,
    input  logic signed [SMP_W-1:0] sin2,
    output logic                    v3,
    output iq_t                     byp3,
    output iq_t                     osc3,
    output iq_t                     mix3
);

    logic signed [2*SMP_W-1:0] p_ic, p_qs, p_is, p_qc;
    logic signed [MIX_W-1:0]   re_n, im_n;
    logic signed [MIX_W-1:0]   re3, im3;

    always_comb begin
        p_ic = d2.i * cos2;
        p_qs = d2.q * sin2;
        p_is = d2.i * sin2;
        p_qc = d2.q * cos2;
        re_n = MIX_W'(p_ic) - MIX_W'(p_qs);
        im_n = MIX_W'(p_is) + MIX_W'(p_qc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v3   <= 1'b0;
            byp3 <= '0;
            osc3 <= '0;
            re3  <= '0;
            im3  <= '0;
        end else begin
            v3 <= v2;
            if (v2) begin
                byp3   <= d2;
                osc3.i <= cos2;
                osc3.q <= sin2;
                re3    <= re_n;
                im3    <= im_n;
            end
        end
    end

    always_comb begin
        mix3.i = round_sat(re3);
        mix3.q = round_sat(im3);
    end

endmodule

// File: rtl/mixer_out_stage.sv
`timescale 1ns/1ps
module mixer_out_stage
    import mixer_readout_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               commit,
    input  sel_e               sel,
    input  run_e               run,
    input  logic [COUNT_W-1:0] count,
    input  logic               v3,
    input  iq_t                byp3,
    input  iq_t                osc3,
    input  iq_t                mix3,
    output logic               m_valid,
    output iq_t                m_data
);

    logic [COUNT_W-1:0] sent;
    logic               room;
    logic               fire;
    iq_t                pick;

    always_comb begin
        unique case (sel)
            SEL_OSC:    pick = osc3;
            SEL_BYPASS: pick = byp3;
            default:    pick = mix3;
        endcase
        room = (run == RUN_FREE) || (sent < count);
        fire = v3 && room;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            m_valid <= 1'b0;
            m_data  <= '0;
            sent    <= '0;
        end else begin
            m_valid <= fire;
            if (fire) m_data <= pick;
            if (commit)                          sent <= '0;
            else if (fire && run == RUN_COUNT)   sent <= sent + 1'b1;
        end
    end

    // R10
    count_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (run == RUN_COUNT) |-> sent <= count);

    // R10
    count_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (run == RUN_COUNT && sent == count && !commit) |=> !m_valid);

    // R11
    free_run_chk: assert property (@(posedge clk) disable iff (rst)
        (run == RUN_FREE && v3) |=> m_valid);

    // R12
    valid_source_chk: assert property (@(posedge clk) disable iff (rst)
        m_valid |-> $past(v3));

endmodule

// File: rtl/mixer_readout.sv
`timescale 1ns/1ps
module mixer_readout
    import mixer_readout_pkg::*;
#(
    parameter int LUT_AW = 8
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [2:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic        s_tvalid,
    input  logic [31:0] s_tdata,
    output logic        m_tvalid,
    output logic [31:0] m_tdata
);

    cfg_t               live;
    logic               commit;
    logic [PHASE_W-1:0] load_phase;
    iq_t                in_s;
    logic               v2, v3;
    iq_t                d2, byp3, osc3, mix3, out_w;
    logic signed [SMP_W-1:0] cos2, sin2;

    assign in_s = s_tdata;

    mixer_cfg_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (cfg_wr),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .load_phase (load_phase),
        .live       (live),
        .commit     (commit)
    );

    mixer_nco #(.LUT_AW(LUT_AW)) u_nco (
        .clk        (clk),
        .rst        (rst),
        .commit     (commit),
        .load_phase (load_phase),
        .step       (live.step),
        .in_valid   (s_tvalid),
        .in_data    (in_s),
        .v2         (v2),
        .d2         (d2),
        .cos2       (cos2),
        .sin2       (sin2)
    );

    mixer_cmul u_cmul (
        .clk  (clk),
        .rst  (rst),
        .v2   (v2),
        .d2   (d2),
        .cos2 (cos2),
        .sin2 (sin2),
        .v3   (v3),
        .byp3 (byp3),
        .osc3 (osc3),
        .mix3 (mix3)
    );

    mixer_out_stage u_out (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .sel     (live.sel),
        .run     (live.run),
        .count   (live.count),
        .v3      (v3),
        .byp3    (byp3),
        .osc3    (osc3),
        .mix3    (mix3),
        .m_valid (m_tvalid),
        .m_data  (out_w)
    );

    assign m_tdata = out_w;

endmodule

// File: tb/mixer_readout_tb_top.sv
`timescale 1ns/1ps
module mixer_readout_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        s_tvalid = 1'b0;
    logic [31:0] s_tdata = '0;
    logic        m_tvalid;
    logic [31:0] m_tdata;

    always #2.5 clk = ~clk;

    mixer_readout #(.LUT_AW(8)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .s_tvalid  (s_tvalid),
        .s_tdata   (s_tdata),
        .m_tvalid  (m_tvalid),
        .m_tdata   (m_tdata)
    );

    typedef struct {
        logic [31:0] word;
        int          tol;
        string       tag;
    } exp_t;

    exp_t  sb_q[$];
    int    n_checks = 0;
    int    n_fails  = 0;
    bit    finished = 0;
    string cur_tag  = "R1";

    // bench model of staged and live settings
    logic [31:0] st_step = 0, st_phase = 0, lv_step = 0;
    int          st_count = 10, lv_count = 10;
    int          st_sel = 0, lv_sel = 0;
    int          st_run = 1, lv_run = 1;
    logic [31:0] m_acc = 0;
    int          m_sent = 0;

    function automatic int tsin(input int k);
        real r;
        r = 32767.0 * $sin(6.283185307179586 * real'(k % 256) / 256.0);
        return int'(r);
    endfunction

    function automatic int rnd_sat(input longint v);
        longint t;
        t = (v + 64'sd16384) >>> 15;
        if (t > 32767)  t = 32767;
        if (t < -32768) t = -32768;
        return int'(t);
    endfunction

    function automatic int s16(input logic [15:0] h);
        return int'($signed(h));
    endfunction

    task automatic fail_line(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_fails++;
        $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    endtask

    // monitor / scoreboard
    exp_t mon_e;
    int   mon_ai, mon_aq, mon_ei, mon_eq;
    always @(negedge clk) begin
        if (!rst && m_tvalid) begin
            n_checks++;
            if (sb_q.size() == 0) begin
                fail_line(cur_tag, "unexpected output word", m_tdata, 32'h0);
            end else begin
                mon_e  = sb_q.pop_front();
                mon_ai = s16(m_tdata[15:0]);
                mon_aq = s16(m_tdata[31:16]);
                mon_ei = s16(mon_e.word[15:0]);
                mon_eq = s16(mon_e.word[31:16]);
                if ((mon_ai - mon_ei > mon_e.tol) || (mon_ei - mon_ai > mon_e.tol) ||
                    (mon_aq - mon_eq > mon_e.tol) || (mon_eq - mon_aq > mon_e.tol))
                    fail_line(mon_e.tag, "output word", m_tdata, mon_e.word);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cfg_wr    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        case (a)
            3'd0: st_step  = d;
            3'd1: st_phase = d;
            3'd2: st_count = int'(d[15:0]);
            3'd3: st_sel   = int'(d[1:0]);
            3'd4: st_run   = int'(d[0]);
            default: ;
        endcase
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic commit_cfg();
        wr(3'd5, 32'd1);
        wr(3'd5, 32'd0);
        lv_step  = st_step;
        lv_count = st_count;
        lv_sel   = st_sel;
        lv_run   = st_run;
        m_acc    = st_phase;
        m_sent   = 0;
    endtask

    task automatic expect_for(input int i, input int q, input string tag);
        exp_t e;
        int   k, c, s;
        logic [31:0] w;
        w = {q[15:0], i[15:0]};
        k = int'(m_acc[31:24]);
        if (lv_run == 1 || m_sent < lv_count) begin
            c = tsin(k + 64);
            s = tsin(k);
            e.tag = tag;
            if (lv_sel == 1) begin
                e.word = {s[15:0], c[15:0]};
                e.tol  = 1;
            end else if (lv_sel == 2) begin
                e.word = w;
                e.tol  = 0;
            end else begin
                int re, im;
                re = rnd_sat(longint'(i) * c - longint'(q) * s);
                im = rnd_sat(longint'(i) * s + longint'(q) * c);
                e.word = {im[15:0], re[15:0]};
                e.tol  = 2;
            end
            sb_q.push_back(e);
            if (lv_run == 0) m_sent++;
        end
        m_acc = m_acc + lv_step;
    endtask

    task automatic send(input int i, input int q, input string tag);
        expect_for(i, q, tag);
        s_tvalid = 1'b1;
        s_tdata  = {q[15:0], i[15:0]};
        @(negedge clk);
        s_tvalid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(input string tag);
        repeat (10) @(negedge clk);
        n_checks++;
        if (sb_q.size() != 0) begin
            fail_line(tag, "missing output words", 32'(sb_q.size()), 32'h0);
            sb_q.delete();
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int seen;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state and defaults
        cur_tag = "R1";
        n_checks++;
        if (m_tvalid !== 1'b0) fail_line("R1", "m_tvalid after reset", 32'(m_tvalid), 32'h0);
        send(1000, -2000, "R1");
        send(-32768, 32767, "R1");
        send(123, 45, "R1");
        drain("R1");

        // R2 staged writes have no effect before commit
        cur_tag = "R2";
        wr(3'd3, 32'd2);
        wr(3'd4, 32'd0);
        wr(3'd2, 32'd1);
        wr(3'd0, 32'h0300_0000);
        send(700, -300, "R2");
        send(-5, 9, "R2");
        drain("R2");
        // commit: bypass, count mode, one word only
        commit_cfg();
        cur_tag = "R10";
        send(11, 22, "R10");
        send(33, 44, "R10");
        send(55, 66, "R10");
        drain("R10");

        // R8 bypass, free running
        cur_tag = "R8";
        wr(3'd4, 32'd1);
        commit_cfg();
        send(32767, -32768, "R8");
        send(-1, 0, "R8");
        send(16'h1234, -16'sd1, "R8");
        drain("R8");

        // R5 oscillator output with gaps, quarter-wave start
        cur_tag = "R5";
        wr(3'd3, 32'd1);
        wr(3'd0, 32'h0400_0000);
        wr(3'd1, 32'h4000_0000);
        commit_cfg();
        for (int n = 0; n < 6; n++) begin
            send(n, -n, "R5");
            idle(n % 3);
        end
        drain("R5");

        // R3 commit restarts phase; R4 index from top bits
        cur_tag = "R3";
        wr(3'd0, 32'h0100_0000);
        wr(3'd1, 32'h8000_0000);
        commit_cfg();
        send(0, 0, "R3");
        send(0, 0, "R3");
        send(0, 0, "R3");
        drain("R3");
        commit_cfg();
        send(0, 0, "R3");
        idle(3);
        send(0, 0, "R3");
        drain("R3");
        cur_tag = "R4";
        wr(3'd0, 32'h00A3_D70A);
        wr(3'd1, 32'h00FF_FFFF);
        commit_cfg();
        for (int n = 0; n < 8; n++) send(0, 0, "R4");
        drain("R4");

        // R6 rotation with a fractional step
        cur_tag = "R6";
        wr(3'd3, 32'd0);
        wr(3'd0, 32'h00A3_D70A);
        wr(3'd1, 32'h1234_5678);
        commit_cfg();
        for (int n = 0; n < 10; n++) send(3000 * n - 14000, 20000 - 4100 * n, "R6");
        drain("R6");

        // R7 clamping at 45 degrees
        cur_tag = "R7";
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h2000_0000);
        commit_cfg();
        send(32767, -32768, "R7");
        send(-32768, 32767, "R7");
        send(-32768, -32768, "R7");
        send(32767, 32767, "R7");
        drain("R7");

        // R9 select value 3 acts as product
        cur_tag = "R9";
        wr(3'd3, 32'd3);
        wr(3'd0, 32'h0100_0000);
        wr(3'd1, 32'h0);
        commit_cfg();
        lv_sel = 0;
        send(9000, 1000, "R9");
        send(-7000, 2500, "R9");
        send(100, -30000, "R9");
        send(32767, 0, "R9");
        drain("R9");

        // R10 counted output, restart on commit, zero count
        cur_tag = "R10";
        wr(3'd3, 32'd0);
        wr(3'd4, 32'd0);
        wr(3'd2, 32'd5);
        commit_cfg();
        for (int n = 0; n < 8; n++) send(n * 100, 50, "R10");
        drain("R10");
        send(1, 1, "R10");
        send(2, 2, "R10");
        drain("R10");
        commit_cfg();
        for (int n = 0; n < 6; n++) send(-n * 200, 7, "R10");
        drain("R10");
        wr(3'd2, 32'd0);
        commit_cfg();
        send(4, 4, "R10");
        send(5, 5, "R10");
        drain("R10");

        // R11 free running, back-to-back
        cur_tag = "R11";
        wr(3'd4, 32'd1);
        wr(3'd0, 32'h0731_0000);
        commit_cfg();
        for (int n = 0; n < 20; n++) send(1500 * n - 15000, 900 - 90 * n, "R11");
        drain("R11");

        // R12 latency of one sample
        cur_tag = "R12";
        seen = 0;
        expect_for(2222, -1111, "R12");
        s_tvalid = 1'b1;
        s_tdata  = {16'hFBA9, 16'h08AE};
        for (int c = 1; c <= 8; c++) begin
            @(negedge clk);
            if (c == 1) s_tvalid = 1'b0;
            if (m_tvalid && seen == 0) seen = c;
        end
        n_checks++;
        if (seen != 4) fail_line("R12", "latency in cycles", 32'(seen), 32'd4);
        drain("R12");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule